// File: doc/BRIEF.md
# Eight-Bit ALU with Output Shifter and Link Bit

This block is the arithmetic core of a small microcoded datapath. It takes an X operand, which is either an 8-bit accumulator-style value or a zero-extended 5-bit constant, and an 8-bit Y operand. It applies one of sixteen operations to them, then passes the result through a one-place shifter. A ninth "link" bit sits above bit 7 of the result. Before the shift, the link bit can be kept, cleared, set or loaded with the carry-out.

The block also produces negative, zero, overflow and carry flags for the current operation. An 8-bit flags register captures these flags in its low nibble, but only on cycles where the load enable is high. Microcode uses the live flags for branching and the registered flags as the architectural condition codes.

Top module: `alu_shift_unit`

## Requirements
- R1: Operation codes 0..7 give, in order: X, Y, X+Y, X+Y+1, X&Y, X|Y, X^Y, ~Y (all modulo 256).
- R2: Operation codes 8..15 give, in order: X+1, Y+1, X&1, Y&1, Y+~X+1, ~X, 8'hFF, 8'h00.
- R3: When `x_is_const` is 1, X is `k_const` zero-extended to 8 bits; otherwise X is `x_opnd`.
- R4: `nzvc_o` is {N,Z,V,C} in bits 3..0. N is bit 7 and Z is the all-zero test of the unshifted ALU result.
- R5: On codes 2, 3, 8, 9 and 12, C is the adder carry-out of bit 7. V is set when the two adder inputs share a sign and the sum's sign differs. The adder inputs are (X,Y), (X,Y), (X,0), (Y,0) and (Y,~X), and every code except 2 adds a carry-in of 1. All other codes force V=0 and C=0.
- R6: `l_mode` selects the pre-shift link value: 0 keeps `l_q`, 1 gives 0, 2 gives 1, 3 gives C. With no left shift, `l_q` takes that value at the next clock.
- R7: `sh_mode`=1 shifts right: `res` = {link, alu[7:1]}, and the link bit is kept. `sh_mode`=2 shifts left: `res` = {alu[6:0],0}, and `l_q` takes alu[7] at the next clock.
- R8: `sh_mode` 0 and the unused code 3 both pass the ALU result through unshifted.
- R9: When `flag_ld` is 1, `flags_q[3:0]` takes `nzvc_o` at the clock edge. When `flag_ld` is 0, `flags_q` holds. `flags_q[7:4]` is always 0.
- R10: While `rst_n` is low, `l_q` and `flags_q` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_sel | input | 4 | Operation code |
| x_opnd | input | 8 | Register X operand |
| k_const | input | 5 | Constant X operand |
| x_is_const | input | 1 | Selects constant as X |
| y_opnd | input | 8 | Y operand |
| l_mode | input | 2 | Link bit control |
| sh_mode | input | 2 | Shift control |
| flag_ld | input | 1 | Flags register load enable |
| res | output | 8 | Shifted result |
| nzvc_o | output | 4 | Live N,Z,V,C flags |
| l_q | output | 1 | Registered link bit |
| flags_q | output | 8 | Registered flags |

## Verification
A wrong opcode decode or a bad adder input shows up at once, in the same cycle, as a wrong `res` and a wrong `nzvc_o`. A corrupted link bit stays hidden until a right shift or a keep-mode carries it into `res` or `l_q`, which can be many cycles later. The bench therefore tracks its own link model through long mixed runs. A flags register that loads or holds wrongly is visible at `flags_q` one edge after the stimulus.

// File: rtl/alu_shift_unit.sv
module alu_shift_unit #(
  parameter int W  = 8,
  parameter int KW = 5,
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    op_sel,
  input  logic [W-1:0]  x_opnd,
  input  logic [KW-1:0] k_const,
  input  logic          x_is_const,
  input  logic [W-1:0]  y_opnd,
  input  logic [1:0]    l_mode,
  input  logic [1:0]    sh_mode,
  input  logic          flag_ld,
  output logic [W-1:0]  res,
  output logic [3:0]    nzvc_o,
  output logic          l_q,
  output logic [FW-1:0] flags_q
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] xv, add_a, add_b, alu;
  logic         add_ci, arith, c_f, v_f, l_pre, l_nxt;
  logic [W:0]   sum;

  assign xv = x_is_const ? W'(k_const) : x_opnd;

  always_comb begin
    add_a  = xv;
    add_b  = y_opnd;
    add_ci = 1'b0;
    arith  = 1'b0;
    case (op_sel)
      4'd2:  arith = 1'b1;
      4'd3:  begin arith = 1'b1; add_ci = 1'b1; end
      4'd8:  begin arith = 1'b1; add_b = '0; add_ci = 1'b1; end
      4'd9:  begin arith = 1'b1; add_a = y_opnd; add_b = '0; add_ci = 1'b1; end
      4'd12: begin arith = 1'b1; add_a = y_opnd; add_b = ~xv; add_ci = 1'b1; end
      default: ;
    endcase
  end

  assign sum = {1'b0, add_a} + {1'b0, add_b} + {{W{1'b0}}, add_ci};

  always_comb begin
    case (op_sel)
      4'd0:    alu = xv;
      4'd1:    alu = y_opnd;
      4'd4:    alu = xv & y_opnd;
      4'd5:    alu = xv | y_opnd;
      4'd6:    alu = xv ^ y_opnd;
      4'd7:    alu = ~y_opnd;
      4'd10:   alu = xv & ONE;
      4'd11:   alu = y_opnd & ONE;
      4'd13:   alu = ~xv;
      4'd14:   alu = '1;
      4'd15:   alu = '0;
      default: alu = sum[W-1:0];
    endcase
  end

  assign c_f = arith & sum[W];
  assign v_f = arith & (add_a[W-1] == add_b[W-1]) & (sum[W-1] != add_a[W-1]);
  assign nzvc_o = {alu[W-1], alu == '0, v_f, c_f};

  always_comb begin
    case (l_mode)
      2'd0:    l_pre = l_q;
      2'd1:    l_pre = 1'b0;
      2'd2:    l_pre = 1'b1;
      default: l_pre = c_f;
    endcase
  end

  always_comb begin
    l_nxt = l_pre;
    case (sh_mode)
      2'd1:    res = {l_pre, alu[W-1:1]};
      2'd2:    begin res = {alu[W-2:0], 1'b0}; l_nxt = alu[W-1]; end
      default: res = alu;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_q     <= 1'b0;
      flags_q <= '0;
    end else begin
      l_q <= l_nxt;
      if (flag_ld) flags_q <= FW'(nzvc_o);
    end
  end
endmodule

module alu_shift_unit_chk #(
  parameter int W  = 8,
  parameter int KW = 5,
  parameter int FW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    op_sel,
  input logic [1:0]    l_mode,
  input logic [1:0]    sh_mode,
  input logic          flag_ld,
  input logic [W-1:0]  res,
  input logic [3:0]    nzvc_o,
  input logic          l_q,
  input logic [FW-1:0] flags_q
);
  assert_flag_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ld |=> flags_q[3:0] == $past(nzvc_o));
  assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_ld |=> $stable(flags_q));
  assert_flag_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q[FW-1:4] == '0);
  assert_l_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (l_mode == 2'd1 && sh_mode != 2'd2) |=> !l_q);
  assert_l_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (l_mode == 2'd2 && sh_mode != 2'd2) |=> l_q);
  assert_left_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sh_mode == 2'd2 |-> res[0] == 1'b0);
  assert_zero_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_mode == 2'd0 || sh_mode == 2'd3) |-> nzvc_o[2] == (res == '0));
  assert_logic_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_sel inside {4'd2, 4'd3, 4'd8, 4'd9, 4'd12}) |-> nzvc_o[1:0] == 2'b00);
endmodule

bind alu_shift_unit alu_shift_unit_chk #(.W(W), .KW(KW), .FW(FW)) u_chk (.*);

// File: tb/alu_shift_unit_bench.sv
module alu_shift_unit_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [3:0] op_sel = '0;
  logic [7:0] x_opnd = '0, y_opnd = '0;
  logic [4:0] k_const = '0;
  logic       x_is_const = 1'b0, flag_ld = 1'b0;
  logic [1:0] l_mode = '0, sh_mode = '0;
  logic [7:0] res, flags_q;
  logic [3:0] nzvc_o;
  logic       l_q;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  alu_shift_unit u_alu_shift_unit (.*);

  function automatic int sgn(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // returns {c, v, r[7:0]}
  function automatic int model(int op, int x, int y);
    int r, c, v, s;
    r = 0; c = 0; v = 0;
    case (op)
      0: r = x;  1: r = y;
      2: begin s = x + y;       c = s > 255; v = (sgn(x) + sgn(y) > 127) || (sgn(x) + sgn(y) < -128); r = s % 256; end
      3: begin s = x + y + 1;   c = s > 255; v = (sgn(x) + sgn(y) + 1 > 127) || (sgn(x) + sgn(y) + 1 < -128); r = s % 256; end
      4: r = x & y;  5: r = x | y;  6: r = x ^ y;  7: r = 255 - y;
      8: begin c = (x == 255); v = (x == 127); r = (x + 1) % 256; end
      9: begin c = (y == 255); v = (y == 127); r = (y + 1) % 256; end
      10: r = x & 1;  11: r = y & 1;
      12: begin c = (y >= x); v = (sgn(y) - sgn(x) > 127) || (sgn(y) - sgn(x) < -128); r = (y - x + 256) % 256; end
      13: r = 255 - x;  14: r = 255;
      default: r = 0;
    endcase
    return (c << 9) | (v << 8) | r;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int l_exp, f_exp;
    l_exp = 0; f_exp = 0;
    flag_ld = 1'b1; l_mode = 2'd2;
    repeat (3) @(negedge clk);
    chk("R10 link in reset", l_q, 0);
    chk("R10 flags in reset", flags_q, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // combinational sweep: all ops, many operand pairs, no shift
    for (int op = 0; op < 16; op++) begin
      for (int a = 0; a < 256; a += 9) begin
        for (int b = 0; b < 256; b += 11) begin
          int m, x;
          x = a;
          op_sel = 4'(op); x_opnd = 8'(a); y_opnd = 8'(b);
          x_is_const = (b % 4 == 1);
          k_const = 5'(a + b);
          if (x_is_const) x = (a + b) % 32;
          sh_mode = 2'(0); l_mode = 2'd0; flag_ld = 1'b0;
          #0.5;
          m = model(op, x, b);
          chk(op < 8 ? (x_is_const ? "R1 R3 result" : "R1 result") :
                       (x_is_const ? "R2 R3 result" : "R2 result"), res, m & 255);
          chk("R4 R5 flags", nzvc_o,
              (((m & 255) >> 7) << 3) | (((m & 255) == 0) << 2) | (((m >> 8) & 1) << 1) | ((m >> 9) & 1));
        end
      end
    end

    // sequential mix: link modes, shifts, flag loads
    @(negedge clk);
    l_exp = l_q; f_exp = flags_q;
    for (int i = 0; i < 4000; i++) begin
      int m, x, y, op, lm, sh, r, c, lp, rexp, lnext, nz;
      @(negedge clk);
      chk("R6 R7 link reg", l_q, l_exp);
      chk("R9 flags reg", flags_q, f_exp);
      op = i % 16; lm = (i / 16) % 4; sh = (i / 64) % 4;
      x = (i * 37 + 11) % 256; y = (i * 91 + 200) % 256;
      op_sel = 4'(op); x_opnd = 8'(x); y_opnd = 8'(y);
      x_is_const = 1'b0; l_mode = 2'(lm); sh_mode = 2'(sh);
      flag_ld = (i % 3 == 0);
      #0.5;
      m = model(op, x, y);
      r = m & 255; c = (m >> 9) & 1;
      lp = (lm == 0) ? l_exp : (lm == 1) ? 0 : (lm == 2) ? 1 : c;
      lnext = lp;
      if (sh == 1) rexp = (lp << 7) | (r >> 1);
      else if (sh == 2) begin rexp = (r << 1) & 255; lnext = r >> 7; end
      else rexp = r;
      nz = ((r >> 7) << 3) | ((r == 0) << 2) | (((m >> 8) & 1) << 1) | c;
      chk(sh == 3 ? "R8 shift result" : "R7 shift result", res, rexp);
      chk("R4 live flags", nzvc_o, nz);
      l_exp = lnext;
      if (flag_ld) f_exp = nz;
    end
    @(negedge clk);
    chk("R6 link final", l_q, l_exp);
    chk("R9 flags final", flags_q, f_exp);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule